// File: doc/BRIEF.md
# Double-Buffered Shared Program Memory Arbiter

This block lets a read-only signal-processing engine and a host microcontroller share one single-port asynchronous SRAM. A free-running phase sequencer splits time into equal engine and host phases. During an engine phase the engine fetches microcode. During a host phase the host may perform one read or one write. Every SRAM strobe and address is registered. The first cycle of each phase drives the new owner's address with both strobes idle, so the bus can settle before any access.

The SRAM holds two program banks, selected by address bit 8, with general host storage above them. The engine always executes from the bank named by the flip-receive bit. The host reaches the other bank through a fixed window and writes the next program there. It then toggles flip-send and polls flip-receive. The swap happens only when engine address bit 7 falls, which marks the end of a sample period, so the engine never changes bank in the middle of a program pass.

Top module: `shared_sram_arbiter`

## Requirements
- R1: After reset the engine owns the bus. Ownership, shown on `host_phase_o` (0 = engine, 1 = host), then alternates, with every phase lasting exactly PHASE_LEN cycles.
- R2: In an engine phase `sram_we_n_o` stays high. `sram_oe_n_o` is low in every cycle of the phase except the first.
- R3: In an engine phase, SRAM address bits 7..0 equal the engine address sampled at the previous clock edge, and bits 10..9 are zero.
- R4: In an engine phase, SRAM address bit 8 equals the flip-receive value from the previous cycle.
- R5: On the clock edge that sees engine address bit 7 go from 1 to 0, `flip_recv_o` takes the value of `flip_send_i`. At any other time, including when only `flip_send_i` changes, it holds its value.
- R6: In the first cycle of each phase both strobes are high. A host write holds `sram_we_n_o` low for exactly PHASE_LEN-2 cycles and releases it in the last cycle of the phase. The two strobes are never low together.
- R7: When host address bits 10..9 are both zero, SRAM bit 8 equals host bit 8 XOR NOT flip-receive. As a result, host addresses 0x000–0x0FF reach the inactive bank and 0x100–0x1FF reach the active bank. Every other host address passes to the SRAM unchanged.
- R8: `host_req_i` is sampled in the first cycle of a host phase, and that phase performs exactly one access. `host_done_o` pulses for one cycle, two cycles after the phase's last cycle. `host_rdata_o` holds the read data until the next host read completes.
- R9: Each engine phase ends with an `eng_valid_o` pulse. With it, `eng_rdata_o` carries the data read at the engine address of the phase's last cycle.
- R10: During reset, `flip_recv_o`, `host_phase_o`, `host_done_o` and `eng_valid_o` are 0, and both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_addr_i | input | ENG_AW | Engine microcode address |
| eng_rdata_o | output | DW | Engine fetch data |
| eng_valid_o | output | 1 | Engine fetch data valid pulse |
| host_req_i | input | 1 | Host access request, held until done |
| host_we_i | input | 1 | Host write (1) or read (0) |
| host_addr_i | input | HOST_AW | Host memory-mapped address |
| host_wdata_i | input | DW | Host write data |
| host_rdata_o | output | DW | Host read data, held |
| host_done_o | output | 1 | Host access complete pulse |
| flip_send_i | input | 1 | Host bank-swap request bit |
| flip_recv_o | output | 1 | Bank currently executed by the engine |
| sram_addr_o | output | HOST_AW | SRAM address |
| sram_oe_n_o | output | 1 | SRAM output enable, active low |
| sram_we_n_o | output | 1 | SRAM write enable, active low |
| sram_wdata_o | output | DW | SRAM write data |
| sram_rdata_i | input | DW | SRAM read data |
| host_phase_o | output | 1 | Bus owner: 0 engine, 1 host |

## Verification
A wrong flip bit shows at the ports within one engine phase. Address bit 8 then names the wrong bank, and the engine fetches the other program, while a host write through the low window lands in the bank being executed. A phase counter that drifts changes the run length of `host_phase_o` at the very next boundary. A stale host serve flag shows up as a missing or duplicated `host_done_o`, or as a write strobe in a phase that was never requested, within one phase pair. Corrupt captured read data appears on the next `host_done_o` or `eng_valid_o` pulse, at most 2*PHASE_LEN+2 cycles after the access.

// File: rtl/shared_sram_pkg.sv
package shared_sram_pkg;
  typedef enum logic {
    OWNER_ENGINE = 1'b0,
    OWNER_HOST   = 1'b1
  } owner_e;
endpackage

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
  import shared_sram_pkg::*;
#(
  parameter int PHASE_LEN = 4
) (
  input  logic   clk,
  input  logic   rst,
  output owner_e owner_o,
  output logic   first_o,
  output logic   last_o
);
  localparam int CW = (PHASE_LEN > 2) ? $clog2(PHASE_LEN) : 2;
  localparam logic [CW-1:0] LAST_CNT = CW'(PHASE_LEN - 1);

  logic [CW-1:0] cnt_q;
  owner_e        owner_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      owner_q <= OWNER_ENGINE;
    end else if (cnt_q == LAST_CNT) begin
      cnt_q   <= '0;
      owner_q <= (owner_q == OWNER_ENGINE) ? OWNER_HOST : OWNER_ENGINE;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign owner_o = owner_q;
  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == LAST_CNT);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST_CNT); // R1
  AST_OWNER_SWAP_AT_END: assert property (@(posedge clk) disable iff (rst)
    (owner_q != $past(owner_q)) |-> first_o); // R1
endmodule

// File: rtl/sram_flip_tracker.sv
module sram_flip_tracker (
  input  logic clk,
  input  logic rst,
  input  logic eng_msb_i,
  input  logic flip_send_i,
  output logic flip_o
);
  logic msb_q;
  logic flip_q;
  logic period_end;

  assign period_end = msb_q & ~eng_msb_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      msb_q  <= 1'b0;
      flip_q <= 1'b0;
    end else begin
      msb_q <= eng_msb_i;
      if (period_end) flip_q <= flip_send_i;
    end
  end

  assign flip_o = flip_q;

  AST_FLIP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !period_end |=> $stable(flip_o)); // R5
  AST_FLIP_TAKES_SEND: assert property (@(posedge clk) disable iff (rst)
    period_end |=> (flip_o == $past(flip_send_i))); // R5
endmodule

// File: rtl/sram_bus_driver.sv
module sram_bus_driver
  import shared_sram_pkg::*;
#(
  parameter int ENG_AW  = 8,
  parameter int HOST_AW = 11,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  owner_e             owner_i,
  input  logic               first_i,
  input  logic               last_i,
  input  logic               flip_i,
  input  logic [ENG_AW-1:0]  eng_addr_i,
  input  logic               host_req_i,
  input  logic               host_we_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [DW-1:0]      host_wdata_i,
  output logic [HOST_AW-1:0] sram_addr_o,
  output logic               sram_oe_n_o,
  output logic               sram_we_n_o,
  output logic [DW-1:0]      sram_wdata_o,
  output logic               host_phase_o,
  output logic               cap_eng_o,
  output logic               cap_host_o,
  output logic               cap_rd_o
);
  localparam int BANK_BIT = ENG_AW;

  function automatic logic [HOST_AW-1:0] map_host(input logic [HOST_AW-1:0] a,
                                                  input logic f);
    logic [HOST_AW-1:0] r;
    r = a;
    if (a[HOST_AW-1:BANK_BIT+1] == '0) r[BANK_BIT] = a[BANK_BIT] ^ ~f;
    return r;
  endfunction

  logic               serve_q;
  logic [HOST_AW-1:0] nxt_addr;
  logic               nxt_oe_n, nxt_we_n, nxt_cap_eng, nxt_cap_host, nxt_cap_rd;
  logic [DW-1:0]      nxt_wdata;

  always_ff @(posedge clk) begin
    if (rst) serve_q <= 1'b0;
    else if (owner_i == OWNER_HOST && first_i) serve_q <= host_req_i;
  end

  always_comb begin
    nxt_addr     = '0;
    nxt_oe_n     = 1'b1;
    nxt_we_n     = 1'b1;
    nxt_wdata    = sram_wdata_o;
    nxt_cap_eng  = 1'b0;
    nxt_cap_host = 1'b0;
    nxt_cap_rd   = 1'b0;
    if (owner_i == OWNER_ENGINE) begin
      nxt_addr[ENG_AW-1:0] = eng_addr_i;
      nxt_addr[BANK_BIT]   = flip_i;
      nxt_oe_n             = first_i;
      nxt_cap_eng          = last_i;
    end else begin
      nxt_addr = map_host(host_addr_i, flip_i);
      if (serve_q) begin
        if (host_we_i) begin
          nxt_we_n  = first_i | last_i;
          nxt_wdata = host_wdata_i;
        end else begin
          nxt_oe_n   = first_i;
          nxt_cap_rd = last_i;
        end
        nxt_cap_host = last_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr_o  <= '0;
      sram_oe_n_o  <= 1'b1;
      sram_we_n_o  <= 1'b1;
      sram_wdata_o <= '0;
      host_phase_o <= 1'b0;
      cap_eng_o    <= 1'b0;
      cap_host_o   <= 1'b0;
      cap_rd_o     <= 1'b0;
    end else begin
      sram_addr_o  <= nxt_addr;
      sram_oe_n_o  <= nxt_oe_n;
      sram_we_n_o  <= nxt_we_n;
      sram_wdata_o <= nxt_wdata;
      host_phase_o <= (owner_i == OWNER_HOST);
      cap_eng_o    <= nxt_cap_eng;
      cap_host_o   <= nxt_cap_host;
      cap_rd_o     <= nxt_cap_rd;
    end
  end

  AST_ENG_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    !host_phase_o |-> sram_we_n_o); // R2
  AST_ENG_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    !host_phase_o |-> (sram_addr_o[HOST_AW-1:BANK_BIT+1] == '0)); // R3
  AST_ENG_BANK_SELECT: assert property (@(posedge clk) disable iff (rst)
    !host_phase_o |-> (sram_addr_o[BANK_BIT] == $past(flip_i))); // R4
  AST_SETTLE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (host_phase_o != $past(host_phase_o)) |-> (sram_oe_n_o && sram_we_n_o)); // R6
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!sram_oe_n_o && !sram_we_n_o)); // R6
endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_eng_i,
  input  logic          cap_host_i,
  input  logic          cap_rd_i,
  input  logic [DW-1:0] sram_rdata_i,
  output logic [DW-1:0] eng_rdata_o,
  output logic          eng_valid_o,
  output logic [DW-1:0] host_rdata_o,
  output logic          host_done_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      eng_rdata_o  <= '0;
      eng_valid_o  <= 1'b0;
      host_rdata_o <= '0;
      host_done_o  <= 1'b0;
    end else begin
      eng_valid_o <= cap_eng_i;
      host_done_o <= cap_host_i;
      if (cap_eng_i) eng_rdata_o <= sram_rdata_i;
      if (cap_rd_i) host_rdata_o <= sram_rdata_i;
    end
  end

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !cap_rd_i |=> $stable(host_rdata_o)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    host_done_o |=> !host_done_o); // R8
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    eng_valid_o |=> !eng_valid_o); // R9
endmodule

// File: rtl/shared_sram_arbiter.sv
module shared_sram_arbiter
  import shared_sram_pkg::*;
#(
  parameter int ENG_AW    = 8,
  parameter int HOST_AW   = 11,
  parameter int DW        = 8,
  parameter int PHASE_LEN = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENG_AW-1:0]  eng_addr_i,
  output logic [DW-1:0]      eng_rdata_o,
  output logic               eng_valid_o,
  input  logic               host_req_i,
  input  logic               host_we_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [DW-1:0]      host_wdata_i,
  output logic [DW-1:0]      host_rdata_o,
  output logic               host_done_o,
  input  logic               flip_send_i,
  output logic               flip_recv_o,
  output logic [HOST_AW-1:0] sram_addr_o,
  output logic               sram_oe_n_o,
  output logic               sram_we_n_o,
  output logic [DW-1:0]      sram_wdata_o,
  input  logic [DW-1:0]      sram_rdata_i,
  output logic               host_phase_o
);
  owner_e owner;
  logic   first, last, flip;
  logic   cap_eng, cap_host, cap_rd;

  sram_phase_seq #(.PHASE_LEN(PHASE_LEN)) u_seq (
    .clk(clk), .rst(rst), .owner_o(owner), .first_o(first), .last_o(last)
  );

  sram_flip_tracker u_flip (
    .clk(clk), .rst(rst), .eng_msb_i(eng_addr_i[ENG_AW-1]),
    .flip_send_i(flip_send_i), .flip_o(flip)
  );

  sram_bus_driver #(.ENG_AW(ENG_AW), .HOST_AW(HOST_AW), .DW(DW)) u_bus (
    .clk(clk), .rst(rst), .owner_i(owner), .first_i(first), .last_i(last),
    .flip_i(flip), .eng_addr_i(eng_addr_i), .host_req_i(host_req_i),
    .host_we_i(host_we_i), .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
    .sram_addr_o(sram_addr_o), .sram_oe_n_o(sram_oe_n_o), .sram_we_n_o(sram_we_n_o),
    .sram_wdata_o(sram_wdata_o), .host_phase_o(host_phase_o),
    .cap_eng_o(cap_eng), .cap_host_o(cap_host), .cap_rd_o(cap_rd)
  );

  sram_read_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst), .cap_eng_i(cap_eng), .cap_host_i(cap_host),
    .cap_rd_i(cap_rd), .sram_rdata_i(sram_rdata_i), .eng_rdata_o(eng_rdata_o),
    .eng_valid_o(eng_valid_o), .host_rdata_o(host_rdata_o), .host_done_o(host_done_o)
  );

  assign flip_recv_o = flip;
endmodule

// File: tb/shared_sram_arbiter_tb_top.sv
`timescale 1ns/1ps
module shared_sram_arbiter_tb_top;
  localparam int ENG_AW = 8;
  localparam int HOST_AW = 11;
  localparam int DW = 8;
  localparam int PL = 4;
  localparam int DEPTH = 1 << HOST_AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ENG_AW-1:0]  eng_addr = '0;
  logic [DW-1:0]      eng_rdata;
  logic               eng_valid;
  logic               host_req = 1'b0, host_we = 1'b0;
  logic [HOST_AW-1:0] host_addr = '0;
  logic [DW-1:0]      host_wdata = '0, host_rdata;
  logic               host_done;
  logic               flip_send = 1'b0, flip_recv;
  logic [HOST_AW-1:0] sram_addr;
  logic               sram_oe_n, sram_we_n, host_phase;
  logic [DW-1:0]      sram_wdata, sram_rdata;

  logic [DW-1:0] mem    [DEPTH];
  logic [DW-1:0] shadow [DEPTH];

  int checks = 0;
  int errors = 0;
  logic flip_exp = 1'b0;
  bit mon_en = 1'b0;

  always #4 clk = ~clk;

  shared_sram_arbiter #(.ENG_AW(ENG_AW), .HOST_AW(HOST_AW), .DW(DW), .PHASE_LEN(PL)) dut_i (
    .clk(clk), .rst(rst), .eng_addr_i(eng_addr), .eng_rdata_o(eng_rdata),
    .eng_valid_o(eng_valid), .host_req_i(host_req), .host_we_i(host_we),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .host_done_o(host_done), .flip_send_i(flip_send), .flip_recv_o(flip_recv),
    .sram_addr_o(sram_addr), .sram_oe_n_o(sram_oe_n), .sram_we_n_o(sram_we_n),
    .sram_wdata_o(sram_wdata), .sram_rdata_i(sram_rdata), .host_phase_o(host_phase)
  );

  // Asynchronous SRAM model: combinational read, write mid-cycle while WE low
  assign sram_rdata = mem[sram_addr];
  always @(negedge clk) if (!sram_we_n) mem[sram_addr] <= sram_wdata;

  function automatic logic [HOST_AW-1:0] exp_map(input logic [HOST_AW-1:0] a, input logic f);
    if (a[10:9] == 2'b00) return {2'b00, a[8] ^ ~f, a[7:0]};
    return a;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic host_access(input logic we, input logic [HOST_AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    do @(negedge clk); while (!host_done);
    host_req = 1'b0;
    if (we) shadow[exp_map(a, flip_exp)] = d;
  endtask

  task automatic host_read_chk(input logic [HOST_AW-1:0] a, input string req);
    logic [DW-1:0] e;
    e = shadow[exp_map(a, flip_exp)];
    host_access(1'b0, a, '0);
    chk(host_rdata === e, req, "host read data", host_rdata, e);
  endtask

  task automatic eng_read_chk(input logic [ENG_AW-1:0] a, input string req);
    logic [DW-1:0] e;
    @(negedge clk);
    eng_addr = a;
    repeat (2) begin
      do @(negedge clk); while (!eng_valid);
    end
    e = shadow[{2'b00, flip_exp, a}];
    chk(eng_rdata === e, req, "engine fetch data", eng_rdata, e);
  endtask

  task automatic period_end();
    @(negedge clk); eng_addr = 8'h80;
    @(negedge clk); eng_addr = 8'h00;
    @(negedge clk);
    flip_exp = flip_send;
  endtask

  // Cycle monitor, sampled 2 ns after each rising edge
  initial begin
    logic prev_phase, prev_flip, seen;
    int run_len, we_low;
    prev_phase = 1'b0; prev_flip = 1'b0; seen = 1'b0; run_len = 0; we_low = 0;
    forever begin
      @(posedge clk); #2;
      if (mon_en) begin
        if (host_phase != prev_phase) begin
          if (seen) chk(run_len == PL, "R1", "phase length", run_len, PL);
          seen = 1'b1;
          chk(sram_oe_n && sram_we_n, "R6", "settle strobes", {sram_oe_n, sram_we_n}, 2'b11);
          if (prev_phase) chk(we_low == 0 || we_low == PL - 2, "R6", "write pulse width", we_low, PL - 2);
          run_len = 1; we_low = 0;
        end else run_len++;
        if (!host_phase) begin
          chk(sram_we_n == 1'b1, "R2", "engine WE", sram_we_n, 1);
          if (run_len > 1) chk(sram_oe_n == 1'b0, "R2", "engine OE", sram_oe_n, 0);
          chk(sram_addr[10:9] == 2'b00 && sram_addr[7:0] == eng_addr, "R3", "engine address",
              sram_addr, {3'b000, eng_addr});
          chk(sram_addr[8] == prev_flip, "R4", "engine bank bit", sram_addr[8], prev_flip);
        end else if (!sram_we_n) we_low++;
        chk(!(!sram_oe_n && !sram_we_n), "R6", "strobe overlap", {sram_oe_n, sram_we_n}, 2'b11);
      end
      prev_phase = host_phase;
      prev_flip = flip_recv;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired: actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    void'($urandom(32'd7013));
    for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    chk(flip_recv == 0 && host_phase == 0 && host_done == 0 && eng_valid == 0, "R10",
        "reset outputs", {flip_recv, host_phase, host_done, eng_valid}, 0);
    chk(sram_oe_n && sram_we_n, "R10", "reset strobes", {sram_oe_n, sram_we_n}, 2'b11);
    rst = 1'b0;
    mon_en = 1'b1;

    // Window write lands in the inactive bank
    host_access(1'b1, 11'h005, 8'hA5);
    chk(mem[11'h105] === 8'hA5, "R7", "inactive bank write", mem[11'h105], 8'hA5);
    host_read_chk(11'h005, "R8");
    host_access(1'b1, 11'h105, 8'h3C);
    chk(mem[11'h005] === 8'h3C, "R7", "active bank write", mem[11'h005], 8'h3C);
    eng_read_chk(8'h05, "R9");
    host_access(1'b1, 11'h600, 8'h77);
    chk(mem[11'h600] === 8'h77, "R7", "pass-through write", mem[11'h600], 8'h77);
    host_read_chk(11'h600, "R7");

    // Toggling send alone must not swap
    @(negedge clk); flip_send = 1'b1;
    repeat (10) @(negedge clk);
    chk(flip_recv == 1'b0, "R5", "flip held without period end", flip_recv, 0);
    eng_read_chk(8'h05, "R4");
    period_end();
    chk(flip_recv == 1'b1, "R5", "flip taken at period end", flip_recv, 1);
    eng_read_chk(8'h05, "R4");
    host_read_chk(11'h105, "R7");
    host_read_chk(11'h005, "R7");

    // Read data held across engine phases
    held = host_rdata;
    repeat (3 * PL) @(negedge clk);
    chk(host_rdata === held, "R8", "read data held", host_rdata, held);

    // Random traffic
    for (int i = 0; i < 30; i++) begin
      logic [HOST_AW-1:0] a;
      a = HOST_AW'($urandom % DEPTH);
      host_access(1'b1, a, DW'($urandom));
    end
    for (int i = 0; i < 30; i++) begin
      logic [HOST_AW-1:0] a;
      a = HOST_AW'($urandom % DEPTH);
      host_read_chk(a, "R7");
    end
    @(negedge clk); flip_send = 1'b0;
    period_end();
    chk(flip_recv == 1'b0, "R5", "flip back to bank 0", flip_recv, 0);
    for (int i = 0; i < 10; i++) eng_read_chk(ENG_AW'($urandom % 128), "R9");
    host_read_chk(11'h105, "R7");

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule